// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the slave-side logic that looks after the 8-bit status register of a serial NOR flash. It works over SPI mode 0. The host drives chip select, serial clock and serial data in, plus an active-low write-protect pin. The block answers on serial data out. It understands three commands: set the write-enable latch, write the status register, and read the status register. A committed status write starts a self-timed busy period. While that period runs, the busy bit stays visible to status reads.

All four SPI pins are sampled by a fast system clock through synchronizer flops, and the clock edges are found by comparing samples. The serial clock must therefore stay well below the system clock: each SPI half period has to last at least five system clocks. The busy period lasts `WR_CYCLES` system clocks. Each command frame is judged when chip select rises, by its exact bit count. A frame that ends early or runs long is dropped.

Status bit layout, as read from the register: bit 7 is the write-lock bit, bit 6 always reads 0, bits 5..2 are protect-level bits, bit 1 is the write-enable latch and bit 0 is the busy flag.

Top module: `sr_spi_ctrl`

## Requirements
- R1: After reset the status register reads 0x00 and `miso` is 0.
- R2: Opcode 0x05 starts a status read. The status byte is shifted out MSB first on `miso`, one bit per falling `sck` edge, starting at the falling edge that follows the eighth opcode bit. The byte repeats for as long as `cs_n` stays low.
- R3: Opcode 0x06 sets the write-enable latch (bit 1), but only when `cs_n` rises after exactly 8 bits. A frame of any other length has no effect.
- R4: A status write never changes bits 6, 1 and 0 from its data byte, and bit 6 always reads 0. Bits 7 and 5..2 take the matching data bits.
- R5: Opcode 0x01 followed by one data byte, both MSB first, commits only when `cs_n` rises after exactly 16 bits. A frame of 15 or 17 bits is dropped, and the latch stays as it was.
- R6: A committed write holds the busy flag (bit 0) at 1 for `WR_CYCLES` system clocks. The latch is cleared at the same moment the busy flag falls.
- R7: A status write issued while the latch is 0 changes nothing.
- R8: When bit 7 is 1 and `wp_n` is low, status writes are refused and the latch stays 1. With `wp_n` high, the same write is accepted.
- R9: While the busy flag is 1, set-latch commands and status writes are ignored.
- R10: Status reads issued during the busy period return busy = 1, so the flag can be polled.
- R11: Any other opcode leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it samples all SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | SPI clock, mode 0 |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data to the host; 0 while deselected |

## Verification
The bench builds the block with `WR_CYCLES` = 400. That is long enough for several complete status reads to fit inside one busy period, so polling and the ignored commands during busy can both be seen at the pins. It is also short enough for a near-exhaustive sweep of data bytes, with a full busy wait after each one. The SPI half period is five system clocks, which brings frame lengths of 8, 9, 15, 16 and 17 bits and the protect-pin combinations into cheap reach.

// File: rtl/sr_spi_ctrl.sv
module sr_spi_ctrl #(
  parameter int WR_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  localparam int TW = $clog2(WR_CYCLES + 1);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;

  logic [2:0] cs_p, sck_p;
  logic [1:0] mosi_p, wp_p;
  logic [4:0] bit_cnt;
  logic [15:0] sh;
  logic rd_mode;
  logic [2:0] rd_idx;
  logic [7:0] shadow;
  logic miso_q;
  logic lock_q, wel_q;
  logic [3:0] lvl_q;
  logic [TW-1:0] tmr;

  wire cs_s    = cs_p[1];
  wire cs_rise = cs_p[2:1] == 2'b01;
  wire sck_r   = !cs_s && sck_p[2:1] == 2'b01;
  wire sck_f   = !cs_s && sck_p[2:1] == 2'b10;
  wire mosi_s  = mosi_p[1];
  wire wip     = tmr != '0;
  wire hpm     = lock_q && !wp_p[1];
  wire [7:0] status = {lock_q, 1'b0, lvl_q, wel_q, wip};

  wire wren_go = cs_rise && bit_cnt == 5'd8  && sh[7:0]  == OP_WREN && !wip;
  wire wrsr_go = cs_rise && bit_cnt == 5'd16 && sh[15:8] == OP_WRSR && wel_q && !wip && !hpm;

  assign miso = miso_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p   <= 3'b111;
      sck_p  <= '0;
      mosi_p <= '0;
      wp_p   <= 2'b11;
    end else begin
      cs_p   <= {cs_p[1:0], cs_n};
      sck_p  <= {sck_p[1:0], sck};
      mosi_p <= {mosi_p[0], mosi};
      wp_p   <= {wp_p[0], wp_n};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
      rd_mode <= 1'b0;
    end else if (cs_s) begin
      bit_cnt <= '0;
      rd_mode <= 1'b0;
    end else if (sck_r) begin
      sh <= {sh[14:0], mosi_s};
      if (bit_cnt != 5'd31) bit_cnt <= bit_cnt + 5'd1;
      if (bit_cnt == 5'd7 && {sh[6:0], mosi_s} == OP_RDSR) rd_mode <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_idx <= '0;
      shadow <= '0;
      miso_q <= 1'b0;
    end else if (cs_s) begin
      rd_idx <= '0;
      miso_q <= 1'b0;
    end else if (sck_f && rd_mode) begin
      rd_idx <= rd_idx + 3'd1;
      if (rd_idx == 3'd0) begin
        shadow <= status;
        miso_q <= status[7];
      end else begin
        miso_q <= shadow[3'd7 - rd_idx];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lock_q <= 1'b0;
      lvl_q  <= '0;
      wel_q  <= 1'b0;
      tmr    <= '0;
    end else begin
      if (wrsr_go) begin
        lock_q <= sh[7];
        lvl_q  <= sh[5:2];
        tmr    <= TW'(WR_CYCLES);
      end else if (wip) begin
        tmr <= tmr - 1'b1;
        if (tmr == TW'(1)) wel_q <= 1'b0;
      end
      if (wren_go) wel_q <= 1'b1;
    end
endmodule

// File: rtl/sr_spi_ctrl_chk.sv
module sr_spi_ctrl_chk #(
  parameter int WR_CYCLES = 50000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       hpm
);
  logic [31:0] busy_run;
  wire [4:0] fields = {status[7], status[5:2]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_run <= '0;
    else if (status[0]) busy_run <= busy_run + 32'd1;
    else busy_run <= '0;

  assert_bit6_zero_R4: assert property (@(posedge clk) disable iff (!rst_n) !status[6]);

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 32'(WR_CYCLES));

  assert_wel_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);

  assert_write_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fields) |-> ($past(status[1]) && !$past(hpm) && !$past(status[0])));

  assert_write_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fields) |-> status[0]);

  assert_wren_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> !$past(status[0]));
endmodule

bind sr_spi_ctrl sr_spi_ctrl_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .status(status), .hpm(hpm)
);

// File: tb/sr_spi_ctrl_tb_top.sv
module sr_spi_ctrl_tb_top;
  localparam int WR = 400;
  localparam int H  = 5;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0, wp_n = 1;
  logic miso;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sr_spi_ctrl #(.WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .wp_n(wp_n), .miso(miso)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] d, input int nb, output logic [31:0] got);
    got = '0;
    @(negedge clk); cs_n = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = d[nb-1-i];
      repeat (H) @(negedge clk);
      got = {got[30:0], miso};
      sck = 1;
      repeat (H) @(negedge clk);
      sck = 0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] v);
    logic [31:0] g;
    xfer(32'h0500, 16, g);
    v = g[7:0];
  endtask

  task automatic wren();
    logic [31:0] g;
    xfer(32'h06, 8, g);
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [31:0] g;
    xfer({16'h0, 8'h01, d}, 16, g);
  endtask

  initial begin
    logic [7:0] v, v2;
    logic [31:0] g;
    int polls;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 miso idle", {7'b0, miso}, 8'h00);
    rd(v); chk("R1 reset status", v, 8'h00);

    xfer(32'h0C, 9, g); rd(v); chk("R3 wren 9 bits ignored", v, 8'h00);
    wrsr(8'hBC); repeat (WR + 20) @(negedge clk);
    rd(v); chk("R7 write without latch", v, 8'h00);
    xfer(32'h9F, 8, g); rd(v); chk("R11 unknown opcode", v, 8'h00);
    wren(); rd(v); chk("R3 wren sets latch", v, 8'h02);

    // R4/R5 sweep
    for (int d = 0; d < 256; d += 3) begin
      wren(); wrsr(8'(d)); repeat (WR + 20) @(negedge clk);
      rd(v); chk("R4 R5 sweep", v, 8'(d) & 8'hBC);
    end

    wren(); wrsr(8'h00); repeat (WR + 20) @(negedge clk);
    wren();
    xfer({17'h0, 8'h01, 7'h1E}, 15, g); rd(v); chk("R5 15-bit frame dropped", v, 8'h02);
    xfer({15'h0, 8'h01, 8'h3C, 1'b1}, 17, g); rd(v); chk("R5 17-bit frame dropped", v, 8'h02);

    // R10 polling and R6 completion
    wrsr(8'h14); rd(v); chk("R10 busy visible", v, 8'h17);
    polls = 1;
    while (v[0] && polls < 12) begin rd(v); polls++; end
    chk("R6 busy ends", {7'b0, v[0]}, 8'h00);
    chk("R6 latch cleared", v, 8'h14);
    chk("R6 busy spans polls", {7'b0, polls > 2}, 8'h01);

    // R9 commands during busy
    wren(); wrsr(8'h28); wrsr(8'h0C); wren(); rd(v);
    chk("R9 write while busy", v, 8'h2B);
    repeat (WR + 20) @(negedge clk);
    rd(v); chk("R9 wren while busy ignored", v, 8'h28);

    // R2 repeated read
    xfer(32'h050000, 24, g);
    chk("R2 first byte", g[15:8], 8'h28);
    chk("R2 repeated byte", g[7:0], 8'h28);

    // R8 hardware protection
    wren(); wrsr(8'h80); repeat (WR + 20) @(negedge clk);
    wp_n = 0; repeat (4) @(negedge clk);
    wren(); wrsr(8'h1C); repeat (WR + 20) @(negedge clk);
    rd(v); chk("R8 protected write refused", v, 8'h82);
    wp_n = 1; repeat (4) @(negedge clk);
    wrsr(8'h1C); repeat (WR + 20) @(negedge clk);
    rd(v2); chk("R8 unprotected write", v2, 8'h1C);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule